// File: doc/BRIEF.md
# Adaptive Transmit FIFO Trigger Level Controller

This block keeps the transmit FIFO threshold: the fill level, counted in 64-byte steps, at which buffered data is released to the transmitter. Control logic raises an up request after a transmit underrun to move the threshold toward the top of its range, a down request to lower it by one step, or a load request to set it directly. An up request climbs by half of the distance that is left to the maximum, rounded down, so repeated underruns approach the ceiling quickly at first and then in smaller steps. A down request never takes the level below the minimum.

Each accepted request runs a fixed three-cycle update: mask, compute and write, restore. While the update runs, the busy output is high and the global interrupt-enable output is held low. Afterwards the enable again follows its configuration input. Every outcome is reported on a sticky error flag: an update that succeeds clears it, and a refused update or a malformed request sets it.

Top module: `trig_level_ctl`

## Requirements
- R1: After reset, level_o equals LVL_MIN (1, meaning 64 bytes), err_o is 0, busy_o is 0 and gie_o is 0.
- R2: An up request on a level below LVL_MAX sets the level to level + floor((LVL_MAX - level) / 2) and clears err_o.
- R3: An up request when the level equals LVL_MAX leaves the level unchanged and sets err_o.
- R4: A down request on a level above LVL_MIN lowers it by exactly one and clears err_o. At LVL_MIN, the level is unchanged and err_o is set.
- R5: A load request with load_val_i in [LVL_MIN, LVL_MAX] writes that value and clears err_o. A value outside that range leaves the level unchanged and sets err_o.
- R6: An accepted request raises busy_o in the following cycle and holds it for exactly three cycles. The level and err_o take their new values at the end of the second busy cycle.
- R7: gie_o is 0 in every cycle in which busy_o is 1. When the block is idle, gie_o follows gie_cfg_i with a delay of one register, so the enable returns once the update ends.
- R8: Two or more of up, down and load asserted in the same idle cycle start no update. The level is unchanged and err_o is 1 in the next cycle.
- R9: Any request asserted while busy_o is 1 is ignored and does not change the result of the update in progress.
- R10: level_o stays within [LVL_MIN, LVL_MAX] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Raise threshold by half the remaining headroom |
| down_req_i | input | 1 | Lower threshold by one step |
| load_req_i | input | 1 | Write load_val_i as the threshold |
| load_val_i | input | LVL_W (6) | Value for a load request |
| gie_cfg_i | input | 1 | Configured global interrupt enable |
| level_o | output | LVL_W (6) | Current threshold in 64-byte units |
| err_o | output | 1 | Sticky result flag of the last operation |
| gie_o | output | 1 | Gated global interrupt enable |
| busy_o | output | 1 | Update sequence in progress |

## Verification
The assertions check the three-cycle busy window on every cycle, along with the low enable while busy and its restoration afterwards, the bounds on the level, the level holding still outside the write cycle, the exact one-step decrease, and the response to conflicting requests. Only the bench scenarios can show that the increment arithmetic gives the right value at each starting level. The same holds for refusals at the ceiling and the floor, for load values outside the range being rejected, and for requests made in the middle of a sequence leaving the result untouched. The bench compares each of these against its own model.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_LOAD = 2'd3
  } trig_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MASK    = 2'd1,
    ST_CALC    = 2'd2,
    ST_RESTORE = 2'd3
  } trig_st_e;

  // Raise by half the headroom, rounded down.
  function automatic int unsigned step_up(int unsigned lvl, int unsigned top);
    return lvl + (top - lvl) / 2;
  endfunction

  function automatic bit in_range(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/trig_seq.sv
module trig_seq
  import trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic busy_o,
  output logic write_o,
  output logic settle_o
);

  trig_st_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      ST_IDLE:    st_d = start_i ? ST_MASK : ST_IDLE;
      ST_MASK:    st_d = ST_CALC;
      ST_CALC:    st_d = ST_RESTORE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign idle_o   = (st_q == ST_IDLE);
  assign busy_o   = (st_q != ST_IDLE);
  assign write_o  = (st_q == ST_CALC);
  assign settle_o = (st_d == ST_IDLE);

endmodule

// File: rtl/trig_calc.sv
module trig_calc
  import trig_pkg::*;
#(
  parameter int unsigned LVL_W   = 6,
  parameter int unsigned LVL_MIN = 1,
  parameter int unsigned LVL_MAX = 48
) (
  input  trig_op_e          op_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [LVL_W-1:0]  ld_val_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              err_o
);

  always_comb begin
    lvl_o = lvl_i;
    err_o = 1'b0;
    unique case (op_i)
      OP_UP: begin
        if (int'(lvl_i) >= LVL_MAX) err_o = 1'b1;
        else lvl_o = LVL_W'(step_up(int'(lvl_i), LVL_MAX));
      end
      OP_DOWN: begin
        if (int'(lvl_i) <= LVL_MIN) err_o = 1'b1;
        else lvl_o = lvl_i - 1'b1;
      end
      OP_LOAD: begin
        if (in_range(int'(ld_val_i), LVL_MIN, LVL_MAX)) lvl_o = ld_val_i;
        else err_o = 1'b1;
      end
      default: err_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/trig_level_ctl.sv
module trig_level_ctl
  import trig_pkg::*;
#(
  parameter int unsigned LVL_W   = 6,
  parameter int unsigned LVL_MIN = 1,
  parameter int unsigned LVL_MAX = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_req_i,
  input  logic             down_req_i,
  input  logic             load_req_i,
  input  logic [LVL_W-1:0] load_val_i,
  input  logic             gie_cfg_i,
  output logic [LVL_W-1:0] level_o,
  output logic             err_o,
  output logic             gie_o,
  output logic             busy_o
);

  localparam logic [LVL_W-1:0] MIN_V = LVL_W'(LVL_MIN);

  logic [2:0]       req_vec;
  logic             multi_req, idle, start, settle;
  logic             proto_evt, write_evt, calc_err;
  trig_op_e         op_req, op_q;
  logic [LVL_W-1:0] ld_q, level_q, calc_lvl;
  logic             err_q, gie_q;

  assign req_vec   = {up_req_i, down_req_i, load_req_i};
  assign multi_req = ($countones(req_vec) > 1);
  assign proto_evt = idle && multi_req;
  assign start     = idle && (req_vec != 3'b000) && !multi_req;

  always_comb begin
    if (up_req_i)        op_req = OP_UP;
    else if (down_req_i) op_req = OP_DOWN;
    else if (load_req_i) op_req = OP_LOAD;
    else                 op_req = OP_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_NONE;
      ld_q <= '0;
    end else if (start) begin
      op_q <= op_req;
      ld_q <= load_val_i;
    end
  end

  trig_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .idle_o   (idle),
    .busy_o   (busy_o),
    .write_o  (write_evt),
    .settle_o (settle)
  );

  trig_calc #(
    .LVL_W   (LVL_W),
    .LVL_MIN (LVL_MIN),
    .LVL_MAX (LVL_MAX)
  ) u_calc (
    .op_i     (op_q),
    .lvl_i    (level_q),
    .ld_val_i (ld_q),
    .lvl_o    (calc_lvl),
    .err_o    (calc_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= MIN_V;
      err_q   <= 1'b0;
    end else if (write_evt) begin
      if (!calc_err) level_q <= calc_lvl;
      err_q <= calc_err;
    end else if (proto_evt) begin
      err_q <= 1'b1;
    end
  end

  // Enable is forced low for every cycle the sequence occupies.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gie_q <= 1'b0;
    else         gie_q <= settle ? gie_cfg_i : 1'b0;
  end

  assign level_o = level_q;
  assign err_o   = err_q;
  assign gie_o   = gie_q;

endmodule

// File: rtl/trig_level_chk.sv
module trig_level_chk
  import trig_pkg::*;
#(
  parameter int unsigned LVL_W   = 6,
  parameter int unsigned LVL_MIN = 1,
  parameter int unsigned LVL_MAX = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gie_cfg_i,
  input logic [LVL_W-1:0] level_o,
  input logic             err_o,
  input logic             gie_o,
  input logic             busy_o,
  input logic             write_evt,
  input logic             proto_evt,
  input logic             calc_err,
  input trig_op_e         op_q
);

  // R10
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(level_o) >= LVL_MIN) && (int'(level_o) <= LVL_MAX));

  // R6
  busy_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ##2 busy_o ##1 !busy_o);

  // R6
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_evt |=> $stable(level_o));

  // R7
  gie_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !gie_o);

  // R7
  gie_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (gie_o == $past(gie_cfg_i)));

  // R8
  proto_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_evt |=> (err_o && $stable(level_o) && !busy_o));

  // R4
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_evt && op_q == OP_DOWN && !calc_err) |=>
      (level_o == $past(level_o) - 1'b1) && !err_o);

endmodule

bind trig_level_ctl trig_level_chk #(
  .LVL_W   (LVL_W),
  .LVL_MIN (LVL_MIN),
  .LVL_MAX (LVL_MAX)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gie_cfg_i (gie_cfg_i),
  .level_o   (level_o),
  .err_o     (err_o),
  .gie_o     (gie_o),
  .busy_o    (busy_o),
  .write_evt (write_evt),
  .proto_evt (proto_evt),
  .calc_err  (calc_err),
  .op_q      (op_q)
);

// File: tb/trig_level_ctl_tb_top.sv
`timescale 1ns/1ps
module trig_level_ctl_tb_top;

  localparam int W  = 6;
  localparam int LO = 1;
  localparam int HI = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up = 1'b0, dn = 1'b0, ld = 1'b0, gcfg = 1'b0;
  logic [W-1:0] val = '0;
  logic [W-1:0] level;
  logic         err, gie, busy;

  int checks = 0;
  int fails  = 0;
  int m_lvl  = LO;
  bit m_err  = 1'b0;

  always #2 clk = ~clk;

  trig_level_ctl #(.LVL_W(W), .LVL_MIN(LO), .LVL_MAX(HI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .up_req_i(up), .down_req_i(dn),
    .load_req_i(ld), .load_val_i(val), .gie_cfg_i(gcfg),
    .level_o(level), .err_o(err), .gie_o(gie), .busy_o(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model: headroom halved with a shift, not the design's function.
  function automatic int model_up(int l);
    return l + ((HI - l) >> 1);
  endfunction

  task automatic run_op(bit u, bit d, bit l, int v, bit g, bit poke);
    int    n = int'(u) + int'(d) + int'(l);
    int    old = m_lvl;
    string tag;
    bit    e = 1'b0;
    int    nl = m_lvl;
    if (u) begin
      tag = (m_lvl == HI) ? "R3" : "R2";
      if (m_lvl == HI) e = 1'b1; else nl = model_up(m_lvl);
    end else if (d) begin
      tag = "R4";
      if (m_lvl == LO) e = 1'b1; else nl = m_lvl - 1;
    end else begin
      tag = "R5";
      if (v >= LO && v <= HI) nl = v; else e = 1'b1;
    end
    @(negedge clk);
    up = u; dn = d; ld = l; val = W'(v); gcfg = g;
    @(negedge clk);
    up = 0; dn = 0; ld = 0;
    if (n == 0) return;
    if (n > 1) begin
      check("R8 busy", int'(busy), 0);
      check("R8 err", int'(err), 1);
      check("R8 level", int'(level), old);
      m_err = 1'b1;
      return;
    end
    check("R6 busy first", int'(busy), 1);
    check("R7 gie masked", int'(gie), 0);
    if (poke) begin up = 1; dn = 0; ld = 1; val = 6'd2; end
    @(negedge clk);
    up = 0; ld = 0;
    check("R6 level not yet", int'(level), old);
    check("R7 gie masked mid", int'(gie), 0);
    @(negedge clk);
    if (poke) tag = {tag, " R9"};
    check({tag, " level"}, int'(level), nl);
    check({tag, " err"}, int'(err), int'(e));
    check("R6 busy third", int'(busy), 1);
    @(negedge clk);
    check("R6 busy end", int'(busy), 0);
    check("R7 gie restored", int'(gie), int'(g));
    m_lvl = nl;
    m_err = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 level", int'(level), LO);
    check("R1 err", int'(err), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 gie", int'(gie), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: down at floor refused
    run_op(0, 1, 0, 0, 1, 0);
    // R2: climb from floor: 1 -> 24 -> 36 ...
    run_op(1, 0, 0, 0, 1, 0);
    run_op(1, 0, 0, 0, 0, 0);
    // R5: out-of-range loads rejected, in-range accepted
    run_op(0, 0, 1, 0, 1, 0);
    run_op(0, 0, 1, 49, 1, 0);
    run_op(0, 0, 1, HI, 1, 0);
    // R3: up at ceiling refused
    run_op(1, 0, 0, 0, 1, 0);
    // R4: successful down
    run_op(0, 1, 0, 0, 1, 0);
    // R8: conflicting requests
    run_op(1, 1, 0, 0, 1, 0);
    run_op(0, 1, 1, 5, 0, 0);
    // R9: request during busy ignored
    run_op(0, 1, 0, 0, 1, 1);
    run_op(0, 0, 1, 7, 1, 1);
    // R7: idle gie follows config
    @(negedge clk); gcfg = 1'b0; @(negedge clk);
    check("R7 idle gie low", int'(gie), 0);
    gcfg = 1'b1; @(negedge clk);
    check("R7 idle gie high", int'(gie), 1);
    for (int i = 0; i < 400; i++) begin
      int  k = $urandom_range(0, 9);
      int  v = $urandom_range(0, 63);
      bit  g = 1'($urandom_range(0, 1));
      bit  p = ($urandom_range(0, 7) == 0);
      if (k < 4)       run_op(1, 0, 0, 0, g, p);
      else if (k < 7)  run_op(0, 1, 0, 0, g, p);
      else if (k < 9)  run_op(0, 0, 1, v, g, p);
      else             run_op(1, 1, 1, v, g, 0);
      check("R10 range", int'(level >= W'(LO) && level <= W'(HI)), 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule